// File: doc/BRIEF.md
# Selector-Steered Alternate Register Bank

This block lets several alternative register banks sit behind one register address. Which bank is seen is not set by address bits. It is set by a small selector field held in a separate control register. Address decoding and the control register's storage live elsewhere. This block receives the whole control word, the contents of every bank, and the per-word write strobes that address decoding has already produced for the shared address.

On the read side, the block compares the selector field with a compile-time table of bank codes. It returns the contents of the bank whose code matches and raises a valid flag. On the write side, it forwards each incoming per-word write strobe only to the matching bank. If no table entry matches, the read data is zero, the valid flag is low and no bank receives a strobe. All outputs are registered, so they reflect the inputs present at the previous rising clock edge.

Top module: `selmux_regbank`

## Requirements
- R1: While rst_n is low, rd_data_o, rd_valid_o and bank_wr_strobe_o are all zero.
- R2: The selector is ctrl_reg_i[SEL_LSB +: SEL_W] (bits 6:4 by default). The other control bits have no effect on any output.
- R3: When the selector equals the code of bank b (bank b's code is BANK_CODES[b*SEL_W +: SEL_W]; the defaults are bank0=0, bank1=3, bank2=5, bank3=6), the cycle after the clock edge rd_data_o word w equals bank_data_i[(b*NUM_WORDS+w)*WORD_W +: WORD_W] and rd_valid_o is 1.
- R4: When the selector matches no table entry (1, 2, 4 and 7 by default), the cycle after the edge rd_data_o is all zeros and rd_valid_o is 0.
- R5: For a matching selector, bank_wr_strobe_o[b*NUM_WORDS+w] of the selected bank equals the wr_strobe_i[w] of the previous edge. The strobes of every other bank are 0.
- R6: For an unmatched selector, every bit of bank_wr_strobe_o is 0, whatever wr_strobe_i holds.
- R7: Each word of each bank has its own strobe. A strobe on word w never raises the strobe of a different word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_reg_i | input | CTRL_W | Control register value that holds the selector field |
| bank_data_i | input | NUM_BANKS*NUM_WORDS*WORD_W | Contents of all banks, bank-major then word |
| wr_strobe_i | input | NUM_WORDS | Per-word write strobes for the shared address |
| rd_data_o | output | NUM_WORDS*WORD_W | Contents of the selected bank, or zero |
| rd_valid_o | output | 1 | High when the selector matched a table code |
| bank_wr_strobe_o | output | NUM_BANKS*NUM_WORDS | Steered write strobes, bank-major then word |

## Verification
On every cycle, the assertions check the following:
- Zero data accompanies a low valid flag.
- At most one bank strobes any given word.
- No strobe leaves the block without a valid match.
- Every outgoing strobe was present on its word's input one cycle earlier.

Only the bench scenarios can show that each particular selector code reaches its particular bank, that the unused control bits are ignored, and that read data follows changes in bank contents.

// File: rtl/smux_pkg.sv
package smux_pkg;

    typedef enum logic [0:0] {
        SEL_MISS = 1'b0,
        SEL_HIT  = 1'b1
    } sel_hit_e;

    function automatic int unsigned flat_index(input int unsigned bank,
                                               input int unsigned word,
                                               input int unsigned nwords);
        return bank * nwords + word;
    endfunction

endpackage

// File: rtl/smux_sel_decode.sv
module smux_sel_decode #(
    parameter int unsigned SEL_W      = 3,
    parameter int unsigned NUM_BANKS  = 4,
    parameter logic [NUM_BANKS*SEL_W-1:0] BANK_CODES = '0
) (
    input  logic [SEL_W-1:0]     sel_i,
    output logic [NUM_BANKS-1:0] hit_o,
    output logic                 hit_any_o
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cmp
        assign hit_o[b] = (sel_i == BANK_CODES[b*SEL_W +: SEL_W]);
    end

    assign hit_any_o = |hit_o;
endmodule

// File: rtl/smux_rd_mux.sv
module smux_rd_mux #(
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned BANK_W    = 32
) (
    input  logic [NUM_BANKS-1:0]        hit_i,
    input  logic [NUM_BANKS*BANK_W-1:0] banks_i,
    output logic [BANK_W-1:0]           data_o
);
    always_comb begin
        data_o = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            data_o = data_o | (banks_i[b*BANK_W +: BANK_W] & {BANK_W{hit_i[b]}});
        end
    end
endmodule

// File: rtl/smux_wr_steer.sv
module smux_wr_steer #(
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned NUM_WORDS = 2
) (
    input  logic [NUM_BANKS-1:0]           hit_i,
    input  logic [NUM_WORDS-1:0]           wr_i,
    output logic [NUM_BANKS*NUM_WORDS-1:0] strb_o
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
            assign strb_o[smux_pkg::flat_index(b, w, NUM_WORDS)] = hit_i[b] & wr_i[w];
        end
    end
endmodule

// File: rtl/selmux_regbank.sv
module selmux_regbank #(
    parameter int unsigned CTRL_W    = 16,
    parameter int unsigned SEL_LSB   = 4,
    parameter int unsigned SEL_W     = 3,
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned NUM_WORDS = 2,
    parameter int unsigned WORD_W    = 16,
    parameter logic [NUM_BANKS*SEL_W-1:0] BANK_CODES = {3'd6, 3'd5, 3'd3, 3'd0}
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [CTRL_W-1:0]                     ctrl_reg_i,
    input  logic [NUM_BANKS*NUM_WORDS*WORD_W-1:0] bank_data_i,
    input  logic [NUM_WORDS-1:0]                  wr_strobe_i,
    output logic [NUM_WORDS*WORD_W-1:0]           rd_data_o,
    output logic                                  rd_valid_o,
    output logic [NUM_BANKS*NUM_WORDS-1:0]        bank_wr_strobe_o
);
    localparam int unsigned BankW = NUM_WORDS * WORD_W;
    localparam int unsigned StrbW = NUM_BANKS * NUM_WORDS;

    function automatic bit codes_unique();
        for (int i = 0; i < NUM_BANKS; i++) begin
            for (int j = i + 1; j < NUM_BANKS; j++) begin
                if (BANK_CODES[i*SEL_W +: SEL_W] == BANK_CODES[j*SEL_W +: SEL_W]) begin
                    return 1'b0;
                end
            end
        end
        return 1'b1;
    endfunction

    localparam bit CodesOk = codes_unique();

    if (!CodesOk) begin : g_bad_table
        $error("selmux_regbank: BANK_CODES holds a repeated code");
    end

    typedef struct packed {
        logic [BankW-1:0] rd_data;
        smux_pkg::sel_hit_e rd_valid;
        logic [StrbW-1:0] strb;
    } state_t;

    state_t state_d, state_q;

    logic [SEL_W-1:0]     sel;
    logic [NUM_BANKS-1:0] hit;
    logic                 hit_any;
    logic [BankW-1:0]     mux_data;
    logic [StrbW-1:0]     steer_strb;

    assign sel = ctrl_reg_i[SEL_LSB +: SEL_W];

    smux_sel_decode #(
        .SEL_W(SEL_W), .NUM_BANKS(NUM_BANKS), .BANK_CODES(BANK_CODES)
    ) u_dec (
        .sel_i(sel), .hit_o(hit), .hit_any_o(hit_any)
    );

    smux_rd_mux #(
        .NUM_BANKS(NUM_BANKS), .BANK_W(BankW)
    ) u_rd (
        .hit_i(hit), .banks_i(bank_data_i), .data_o(mux_data)
    );

    smux_wr_steer #(
        .NUM_BANKS(NUM_BANKS), .NUM_WORDS(NUM_WORDS)
    ) u_wr (
        .hit_i(hit), .wr_i(wr_strobe_i), .strb_o(steer_strb)
    );

    always_comb begin
        state_d          = state_q;
        state_d.rd_valid = hit_any ? smux_pkg::SEL_HIT : smux_pkg::SEL_MISS;
        state_d.rd_data  = hit_any ? mux_data : '0;
        state_d.strb     = hit_any ? steer_strb : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_data_o        = state_q.rd_data;
    assign rd_valid_o       = (state_q.rd_valid == smux_pkg::SEL_HIT);
    assign bank_wr_strobe_o = state_q.strb;
endmodule

// File: rtl/selmux_regbank_chk.sv
module selmux_regbank_chk #(
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned NUM_WORDS = 2,
    parameter int unsigned WORD_W    = 16
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [NUM_WORDS-1:0]           wr_strobe_i,
    input logic [NUM_WORDS*WORD_W-1:0]    rd_data_o,
    input logic                           rd_valid_o,
    input logic [NUM_BANKS*NUM_WORDS-1:0] bank_wr_strobe_o
);
    // R4: a miss never carries data
    p_idle_data_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid_o |-> (rd_data_o == '0));

    // R6: no strobe without a matched selector
    p_no_stray_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|bank_wr_strobe_o) |-> rd_valid_o);

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [NUM_BANKS-1:0] column;
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_col
            assign column[b] = bank_wr_strobe_o[b*NUM_WORDS + w];
        end

        // R5: only one bank strobes each word
        p_single_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(column));

        // R7: an outgoing strobe comes from its own word's input
        p_strobe_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (|column) |-> $past(wr_strobe_i[w]));
    end
endmodule

bind selmux_regbank selmux_regbank_chk #(
    .NUM_BANKS(NUM_BANKS), .NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_strobe_i(wr_strobe_i),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
    .bank_wr_strobe_o(bank_wr_strobe_o)
);

// File: tb/sim_selmux_regbank.sv
module sim_selmux_regbank;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;
    localparam int NW = 2;
    localparam int WW = 16;
    localparam int CW = 16;
    localparam int SEL_BASE = 4;
    localparam int CODES [NB] = '{0, 3, 5, 6};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0] ctrl = '0;
    logic [NB*NW*WW-1:0] banks = '0;
    logic [NW-1:0] wr = '0;
    logic [NW*WW-1:0] rd_data;
    logic rd_valid;
    logic [NB*NW-1:0] strb;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    selmux_regbank u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_reg_i(ctrl), .bank_data_i(banks),
        .wr_strobe_i(wr), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
        .bank_wr_strobe_o(strb)
    );

    function automatic logic [WW-1:0] pattern(int b, int w, int salt);
        return WW'(16'h1000 * (b + 1) + 16'h0011 * (w + 3) + salt);
    endfunction

    function automatic int bank_of(int s);
        for (int b = 0; b < NB; b++) if (CODES[b] == s) return b;
        return -1;
    endfunction

    task automatic load_banks(int salt);
        for (int b = 0; b < NB; b++)
            for (int w = 0; w < NW; w++)
                banks[(b*NW+w)*WW +: WW] = pattern(b, w, salt);
    endtask

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(logic [CW-1:0] c, logic [NW-1:0] s);
        @(negedge clk);
        ctrl = c;
        wr = s;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_all(string req, int sel, logic [NW-1:0] s);
        int b = bank_of(sel);
        logic [NW*WW-1:0] exp_d = '0;
        logic [NB*NW-1:0] exp_s = '0;
        if (b >= 0) begin
            exp_d = banks[b*NW*WW +: NW*WW];
            for (int w = 0; w < NW; w++) exp_s[b*NW+w] = s[w];
        end
        check({req, " data"}, 64'(rd_data), 64'(exp_d));
        check({req, " valid"}, 64'(rd_valid), 64'(b >= 0));
        check({req, " strobe"}, 64'(strb), 64'(exp_s));
    endtask

    task automatic t_reset();
        ctrl = 16'h0030;
        wr = '1;
        load_banks(0);
        #(CLK_PERIOD*3);
        check("R1 data", 64'(rd_data), 64'h0);
        check("R1 valid", 64'(rd_valid), 64'h0);
        check("R1 strobe", 64'(strb), 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_every_selector();
        for (int s = 0; s < 8; s++) begin
            apply(CW'(s << SEL_BASE), 2'b11);
            if (bank_of(s) >= 0) expect_all("R3/R5 matched", s, 2'b11);
            else expect_all("R4/R6 unmatched", s, 2'b11);
        end
    endtask

    task automatic t_word_strobes();
        for (int p = 0; p < 4; p++) begin
            apply(CW'(5 << SEL_BASE), NW'(p));
            expect_all("R7 per-word", 5, NW'(p));
        end
        apply(CW'(7 << SEL_BASE), 2'b01);
        expect_all("R6 unmatched single word", 7, 2'b01);
    endtask

    task automatic t_ignored_bits();
        logic [CW-1:0] mask = CW'(7 << SEL_BASE);
        apply((16'hFFFF & ~mask) | CW'(3 << SEL_BASE), 2'b10);
        expect_all("R2 noise around field", 3, 2'b10);
        apply((16'hA5A5 & ~mask) | CW'(2 << SEL_BASE), 2'b11);
        expect_all("R2 noise unmatched", 2, 2'b11);
    endtask

    task automatic t_data_follow();
        apply(CW'(6 << SEL_BASE), 2'b00);
        @(negedge clk);
        load_banks(7);
        @(posedge clk);
        #1;
        expect_all("R3 content change", 6, 2'b00);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_every_selector();
        t_word_strobes();
        t_ignored_bits();
        t_data_follow();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule